// File: doc/BRIEF.md
# Cascadable serial bitstream streamer

This block feeds a stored FPGA configuration image, one bit per clock, to an FPGA that loads itself in master-serial fashion. The configuring FPGA supplies the clock. The streamer reads 32-bit words from a synchronous memory read port and shifts each word out most significant bit first. A new bit appears after every falling clock edge, so the FPGA can sample it on the rising edge. The memory port samples `mem_addr` on a falling edge and returns the word at the next falling edge. The block always requests the word that follows the one being shifted, so the stream has no gap at word boundaries.

Several devices can share one data line. When the last bit of the last word has gone out, the streamer stops driving its data pin and pulls its cascade output low. That output drives the chip enable of the next device in the chain. The reset input can be active high or active low, chosen by a configuration bit. Chip enable is active low. A mode-select input hands the pins to a two-wire programming interface, which lies outside this block. While that mode is selected, the streamer ignores reset and chip enable.

Top module: `cfg_stream`

## Requirements
- R1: `rst_pol_high` = 0 makes `rst_pin` active low and 1 makes it active high. While reset is active, not in programming mode and after `ready` has risen, the word and bit counters return to zero at the next falling edge and `dout_oe` is 0 at once, whatever `ce_n` is.
- R2: While `ce_n` is 1 and reset is inactive, the counters hold and `dout_oe` is 0. When `ce_n` returns to 0 the stream continues from the bit that was next.
- R3: When reset is released while `ce_n` is 0, `dout_oe` becomes 1 and `dout` shows bit 31 of word 0 before the next rising edge, without waiting for a clock edge.
- R4: Each falling edge with streaming enabled advances exactly one bit. Bits go out from bit 31 down to bit 0 of each word, and words go out at ascending addresses from 0 to DEPTH-1 with no repeated or skipped bit across word boundaries.
- R5: At the falling edge after the last bit of word DEPTH-1, `cascade_n` goes to 0 and `dout_oe` goes to 0.
- R6: Once `cascade_n` is 0 it stays 0 until reset is active at a falling edge, which returns it to 1.
- R7: While `por_n` is 0, `ready` is 0 and `dout_oe` is 0. `ready` rises at the first falling edge after `por_n` goes to 1, and the counters are zero at that point.
- R8: While `prog_mode` is 1, `dout_oe` is 0 and `cascade_n` is 1. `rst_pin` and `ce_n` have no effect, the counters hold, and streaming resumes at the same bit when `prog_mode` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the configuring FPGA; state changes on its falling edge |
| por_n | input | 1 | Power-on reset from the analog detector, active low, asynchronous |
| prog_mode | input | 1 | 1 selects two-wire programming mode, 0 selects streaming mode |
| rst_pin | input | 1 | Reset input with programmable polarity |
| rst_pol_high | input | 1 | Configuration bit: 1 = reset active high, 0 = active low |
| ce_n | input | 1 | Chip enable, active low |
| ready | output | 1 | Goes high once power-on initialisation is complete |
| dout | output | 1 | Serial configuration data |
| dout_oe | output | 1 | Output enable for the data pad; 0 = high impedance |
| cascade_n | output | 1 | Cascade enable to the next device, active low |
| mem_addr | output | AW | Word address for the synchronous memory read port |
| mem_rdata | input | WORD_W | Word read from the memory, valid one falling edge after the address |

## Verification
The memory model returns a word pattern computed from the address, in which every byte differs, so a wrong address, a swapped word or a reversed bit order shows up as a mismatch. The whole image is streamed once with a chip-enable pause in the middle of a word and a programming-mode interruption across other bits. A resumed stream that repeats or drops a bit is therefore caught. A second, shorter stream follows a reset of the opposite polarity. It shows that the counters were cleared and that the polarity bit changes which level of the reset input counts as active. The end-of-memory handoff is checked before and after a programming-mode excursion and after a reset.

// File: rtl/cfg_stream.sv
module cfg_stream #(
  parameter int DEPTH  = 131072,
  parameter int WORD_W = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              prog_mode,
  input  logic              rst_pin,
  input  logic              rst_pol_high,
  input  logic              ce_n,
  output logic              ready,
  output logic              dout,
  output logic              dout_oe,
  output logic              cascade_n,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam logic [AW-1:0] LAST_W = AW'(DEPTH - 1);
  localparam logic [BW-1:0] LAST_B = BW'(WORD_W - 1);

  logic [AW-1:0]     word_q;
  logic [BW-1:0]     bit_q;
  logic [WORD_W-1:0] cur_q;
  logic              done_q;
  logic              ready_q;

  logic rst_act;
  logic load0;
  logic run;

  assign rst_act = rst_pol_high ? rst_pin : ~rst_pin;
  assign load0   = ~ready_q | (~prog_mode & rst_act);
  assign run     = ready_q & ~prog_mode & ~rst_act & ~ce_n & ~done_q;

  assign mem_addr = (load0 || word_q == LAST_W) ? '0 : word_q + 1'b1;

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) begin
      ready_q <= 1'b0;
      word_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
      cur_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (load0) begin
        word_q <= '0;
        bit_q  <= '0;
        done_q <= 1'b0;
        cur_q  <= mem_rdata;
      end else if (run) begin
        if (bit_q == LAST_B) begin
          bit_q <= '0;
          if (word_q == LAST_W) begin
            done_q <= 1'b1;
          end else begin
            word_q <= word_q + 1'b1;
            cur_q  <= mem_rdata;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign ready     = ready_q;
  assign dout_oe   = run;
  assign dout      = run & cur_q[LAST_B - bit_q];
  assign cascade_n = prog_mode | ~done_q;
endmodule

// File: rtl/cfg_stream_chk.sv
module cfg_stream_chk (
  input logic clk,
  input logic por_n,
  input logic prog_mode,
  input logic rst_pin,
  input logic rst_pol_high,
  input logic ce_n,
  input logic ready,
  input logic dout_oe,
  input logic cascade_n
);
  logic rst_on;
  assign rst_on = rst_pol_high ? rst_pin : !rst_pin;

  // R1
  reset_float_chk: assert property (@(negedge clk) disable iff (!por_n)
    (!prog_mode && rst_on) |-> !dout_oe);

  // R2
  standby_float_chk: assert property (@(negedge clk) disable iff (!por_n)
    ce_n |-> !dout_oe);

  // R5
  handoff_float_chk: assert property (@(negedge clk) disable iff (!por_n)
    !cascade_n |-> !dout_oe);

  // R6
  cascade_hold_chk: assert property (@(negedge clk) disable iff (!por_n)
    (!cascade_n && !prog_mode && !rst_on) |=> (!cascade_n || prog_mode || rst_on));

  // R8
  prog_quiet_chk: assert property (@(negedge clk) disable iff (!por_n)
    prog_mode |-> (!dout_oe && cascade_n));

  // R7
  always_comb begin
    if (!ready) begin
      not_ready_float_chk: assert (!dout_oe);
    end
  end
endmodule

bind cfg_stream cfg_stream_chk chk_i (
  .clk(clk), .por_n(por_n), .prog_mode(prog_mode), .rst_pin(rst_pin),
  .rst_pol_high(rst_pol_high), .ce_n(ce_n), .ready(ready),
  .dout_oe(dout_oe), .cascade_n(cascade_n)
);

// File: tb/cfg_stream_tb_top.sv
module cfg_stream_tb_top;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 4;
  localparam int WORD_W = 32;
  localparam int AW     = 2;
  localparam int TOTAL  = DEPTH * WORD_W;

  logic clk = 1'b0;
  logic por_n, prog_mode, rst_pin, rst_pol_high, ce_n;
  logic ready, dout, dout_oe, cascade_n;
  logic [AW-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rdata;

  int  total = 0;
  int  bad = 0;
  bit  q[$];
  bit  mon_on = 1'b0;
  bit  exp_b;
  string tag = "R4";

  always #(CLK_P/2) clk = ~clk;

  cfg_stream #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .por_n(por_n), .prog_mode(prog_mode), .rst_pin(rst_pin),
    .rst_pol_high(rst_pol_high), .ce_n(ce_n), .ready(ready), .dout(dout),
    .dout_oe(dout_oe), .cascade_n(cascade_n), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pattern(int a);
    return {8'(a * 37 + 29), 8'(198 ^ a), 8'(~a), 8'(a * 13 + 129)};
  endfunction

  function automatic bit stream_bit(int i);
    logic [31:0] w;
    w = pattern(i / WORD_W);
    return w[31 - (i % WORD_W)];
  endfunction

  always @(negedge clk) mem_rdata <= pattern(int'(mem_addr));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_bits(int from, int upto);
    for (int i = from; i < upto; i++) q.push_back(stream_bit(i));
  endtask

  task automatic fall();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_left(int n);
    while (q.size() > n) begin
      @(posedge clk);
      #1;
    end
  endtask

  always @(posedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_b = q.pop_front();
      check(dout_oe === 1'b1 && dout === exp_b, tag, "stream bit",
            {dout_oe, dout}, {1'b1, exp_b});
    end
  end

  initial begin
    #(CLK_P * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; prog_mode = 1'b0; rst_pol_high = 1'b0;
    rst_pin = 1'b0; ce_n = 1'b0;
    repeat (3) fall();
    check(ready === 1'b0, "R7", "ready during power-on", ready, 0);
    check(dout_oe === 1'b0, "R7", "oe during power-on", dout_oe, 0);
    por_n = 1'b1;
    #1;
    check(ready === 1'b0, "R7", "ready before first fall", ready, 0);
    fall();
    check(ready === 1'b1, "R7", "ready after fall", ready, 1);
    check(dout_oe === 1'b0, "R1", "oe under active-low reset", dout_oe, 0);
    check(cascade_n === 1'b1, "R1", "cascade under reset", cascade_n, 1);

    // R2 standby at release
    ce_n = 1'b1;
    fall();
    rst_pin = 1'b1;
    repeat (5) begin
      fall();
      check(dout_oe === 1'b0, "R2", "standby oe", dout_oe, 0);
    end
    tag = "R4";
    push_bits(0, TOTAL);
    ce_n = 1'b0;
    mon_on = 1'b1;
    #1;
    check(dout_oe === 1'b1 && dout === stream_bit(0), "R2", "first bit after standby",
          {dout_oe, dout}, {1'b1, stream_bit(0)});

    // R2 pause mid-word
    wait_left(TOTAL - 45);
    fall();
    ce_n = 1'b1;
    mon_on = 1'b0;
    repeat (3) begin
      @(posedge clk);
      #1;
      check(dout_oe === 1'b0, "R2", "paused oe", dout_oe, 0);
    end
    fall();
    ce_n = 1'b0;
    mon_on = 1'b1;

    // R8 programming mode interruption
    wait_left(TOTAL - 80);
    fall();
    prog_mode = 1'b1;
    mon_on = 1'b0;
    rst_pin = 1'b0;
    ce_n = 1'b1;
    repeat (3) begin
      fall();
      check(dout_oe === 1'b0, "R8", "oe in prog mode", dout_oe, 0);
      check(cascade_n === 1'b1, "R8", "cascade in prog mode", cascade_n, 1);
    end
    rst_pin = 1'b1;
    ce_n = 1'b0;
    fall();
    tag = "R8";
    prog_mode = 1'b0;
    mon_on = 1'b1;
    wait_left(TOTAL - 84);
    tag = "R4";
    wait_left(0);

    // R5 end of memory
    fall();
    check(cascade_n === 1'b0, "R5", "cascade at end", cascade_n, 0);
    check(dout_oe === 1'b0, "R5", "oe at end", dout_oe, 0);
    repeat (4) begin
      fall();
      check(cascade_n === 1'b0 && dout_oe === 1'b0, "R6", "cascade held",
            {cascade_n, dout_oe}, 0);
    end
    prog_mode = 1'b1;
    #1;
    check(cascade_n === 1'b1, "R8", "cascade in prog after end", cascade_n, 1);
    fall();
    prog_mode = 1'b0;
    #1;
    check(cascade_n === 1'b0, "R6", "cascade after prog excursion", cascade_n, 0);

    // R6 reset returns cascade high
    fall();
    rst_pin = 1'b0;
    fall();
    check(cascade_n === 1'b1, "R6", "cascade after reset", cascade_n, 1);

    // R1 active-high polarity, R3 immediate first bit
    rst_pol_high = 1'b1;
    rst_pin = 1'b1;
    repeat (3) begin
      fall();
      check(dout_oe === 1'b0, "R1", "oe under active-high reset", dout_oe, 0);
    end
    tag = "R1";
    push_bits(0, 40);
    rst_pin = 1'b0;
    mon_on = 1'b1;
    #1;
    check(dout_oe === 1'b1 && dout === stream_bit(0), "R3", "first bit at release",
          {dout_oe, dout}, {1'b1, stream_bit(0)});
    wait_left(0);
    fall();
    rst_pin = 1'b1;
    #1;
    check(dout_oe === 1'b0, "R1", "oe as active-high reset asserts", dout_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule